// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Top-Wrap Interrupt

This block is a memory-mapped real-time counter for a single clock domain. A slow reference arrives as a one-cycle enable pulse (`ref_tick`). A power-of-two prescaler divides that pulse train. Each terminal count of the prescaler advances a 32-bit value counter.

Software can load the counter at any time. It programs a top value and can choose to have the counter return to zero when the count reaches that top value. Each such wrap latches a pending bit. A mask decides whether the pending bit drives the single interrupt output. The mask is set and cleared through separate write-one registers, and the pending bit has a write-one clear register.

A 32.768 kHz reference with a divider select of 14 gives one count per second. The block is meant to keep time while the rest of the system sleeps, and software seeds it from another time source.

Top module: `rtc_topwrap`

## Requirements
- R1: After reset every readable register reads 0 and `irq` is low.
- R2: Control at byte offset 0x00 has these fields:
  - bit 0: count enable.
  - bit 1: divider-clear strobe, which always reads 0.
  - bit 2: wrap-at-top enable.
  - bits 11:8: divider select.
  All other bits read 0.
- R3: While counting is enabled, the value advances once per 2^(sel+1) `ref_tick` pulses. Writing control with bit 1 set zeroes the divider, so the first advance comes after exactly 2^(sel+1) further pulses.
- R4: While count enable is 0, the value and the divider hold. Setting the enable again resumes counting from the held value.
- R5: A write to offset 0x04 loads the value at any time, and counting continues from the loaded value. A load in the same cycle as an advance wins.
- R6: With wrap enabled, an advance taken while value equals top (offset 0x08) makes the next value 0 and sets the pending bit.
- R7: With wrap disabled, the count passes the top value and rolls from 0xFFFFFFFF to 0 without setting the pending bit.
- R8: Writing 1 to bit 0 of offset 0x10 sets the mask, and writing 1 to bit 0 of offset 0x14 clears it. Bit 0 of offset 0x18 reads the mask.
- R9: Bit 0 of offset 0x1C reads the pending bit whether or not the mask is set. Writing 1 to bit 0 of offset 0x20 clears it. A wrap in the same cycle as that clear leaves the bit set.
- R10: `irq` is high exactly when the pending bit and the mask are both 1.
- R11: Offsets 0x10, 0x14 and 0x20 and any unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt: pending AND mask |

## Verification
A divider that miscounts or fails to clear shows up at offset 0x04 as an off-by-one value. This happens within one 2^(sel+1) window after the clear strobe, so the sweep over small selects and pulse counts catches it within a few dozen cycles. A broken top compare shows up one cycle after the wrapping advance, either as a non-zero value or as a missing pending bit. Wrong set/clear priority, or wrong mask logic, shows on `irq` and offset 0x1C on the cycle right after the offending write.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int SEL_W   = 4;
  localparam int SEL_LSB = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_VAL  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_TOP  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MSET = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MCLR = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_PEND = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_PCLR = 8'h20;

  localparam int CB_RUN  = 0;
  localparam int CB_DCLR = 1;
  localparam int CB_WRAP = 2;
endpackage

// File: rtl/rtcw_regs.sv
module rtcw_regs
  import rtcw_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          run,
  output logic          wrap_on,
  output logic [SW-1:0] sel,
  output logic          div_clr,
  output logic          val_ld,
  output logic          mask_set,
  output logic          mask_clr,
  output logic          pend_clr,
  output logic [DW-1:0] top
);
  logic          ctrl_we, top_we;
  logic          run_n, wrap_n;
  logic [SW-1:0] sel_n;
  logic [DW-1:0] top_n;

  always_comb begin
    ctrl_we  = we && (addr == OFS_CTRL);
    top_we   = we && (addr == OFS_TOP);
    val_ld   = we && (addr == OFS_VAL);
    mask_set = we && (addr == OFS_MSET) && wdata[0];
    mask_clr = we && (addr == OFS_MCLR) && wdata[0];
    pend_clr = we && (addr == OFS_PCLR) && wdata[0];
    div_clr  = ctrl_we && wdata[CB_DCLR];
    run_n    = ctrl_we ? wdata[CB_RUN]  : run;
    wrap_n   = ctrl_we ? wdata[CB_WRAP] : wrap_on;
    sel_n    = ctrl_we ? wdata[SEL_LSB +: SW] : sel;
    top_n    = top_we  ? wdata : top;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      wrap_on <= 1'b0;
      sel     <= '0;
      top     <= '0;
    end else begin
      run     <= run_n;
      wrap_on <= wrap_n;
      sel     <= sel_n;
      top     <= top_n;
    end
  end
endmodule

// File: rtl/rtcw_divider.sv
module rtcw_divider #(
  parameter int SW = 4,
  localparam int PW = 1 << SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ref_tick,
  input  logic          clr,
  input  logic [SW-1:0] sel,
  output logic          adv
);
  logic [PW-1:0] cnt, cnt_n, span;

  always_comb begin
    for (int i = 0; i < PW; i++) span[i] = (i <= int'(sel));
    adv   = run && ref_tick && (&(cnt | ~span));
    cnt_n = cnt;
    if (clr)                  cnt_n = '0;
    else if (run && ref_tick) cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/rtcw_counter.sv
module rtcw_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic          wrap_on,
  input  logic [DW-1:0] top,
  output logic [DW-1:0] value,
  output logic          wrap_evt
);
  logic [DW-1:0] value_n;

  always_comb begin
    wrap_evt = 1'b0;
    value_n  = value;
    if (ld) begin
      value_n = ld_val;
    end else if (adv) begin
      if (wrap_on && (value == top)) begin
        value_n  = '0;
        wrap_evt = 1'b1;
      end else begin
        value_n = value + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= value_n;
  end
endmodule

// File: rtl/rtcw_irq.sv
module rtcw_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic mask_set,
  input  logic mask_clr,
  input  logic pend_clr,
  output logic pend,
  output logic mask,
  output logic irq
);
  logic pend_n, mask_n;

  always_comb begin
    pend_n = evt ? 1'b1 : (pend_clr ? 1'b0 : pend);
    mask_n = mask_clr ? 1'b0 : (mask_set ? 1'b1 : mask);
    irq    = pend & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      mask <= 1'b0;
    end else begin
      pend <= pend_n;
      mask <= mask_n;
    end
  end
endmodule

// File: rtl/rtc_topwrap.sv
module rtc_topwrap
  import rtcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [1:0]        rst_q;
  logic              rst_ni;
  logic              run, wrap_on, div_clr, val_ld;
  logic              mask_set, mask_clr, pend_clr;
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] top, value;
  logic              adv, wrap_evt, pend, mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  rtcw_regs #(.AW(ADDR_W), .DW(DATA_W), .SW(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_ni), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .run(run), .wrap_on(wrap_on), .sel(sel), .div_clr(div_clr), .val_ld(val_ld),
    .mask_set(mask_set), .mask_clr(mask_clr), .pend_clr(pend_clr), .top(top)
  );

  rtcw_divider #(.SW(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_ni), .run(run), .ref_tick(ref_tick),
    .clr(div_clr), .sel(sel), .adv(adv)
  );

  rtcw_counter #(.DW(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .adv(adv), .ld(val_ld), .ld_val(bus_wdata),
    .wrap_on(wrap_on), .top(top), .value(value), .wrap_evt(wrap_evt)
  );

  rtcw_irq u_irq (
    .clk(clk), .rst_n(rst_ni), .evt(wrap_evt), .mask_set(mask_set),
    .mask_clr(mask_clr), .pend_clr(pend_clr), .pend(pend), .mask(mask), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[CB_RUN]             = run;
        bus_rdata[CB_WRAP]            = wrap_on;
        bus_rdata[SEL_LSB +: SEL_W]   = sel;
      end
      OFS_VAL:  bus_rdata = value;
      OFS_TOP:  bus_rdata = top;
      OFS_MASK: bus_rdata[0] = mask;
      OFS_PEND: bus_rdata[0] = pend;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtcw_checker.sv
module rtcw_checker
  import rtcw_pkg::*;
(
  input logic              clk,
  input logic              rst_ni,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              run,
  input logic              wrap_evt,
  input logic [DATA_W-1:0] value,
  input logic              pend,
  input logic              mask,
  input logic              irq
);
  // R9: a wrap beats a same-cycle clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    wrap_evt |=> pend);
  // R9: a clear with no wrap drops the pending bit
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && bus_addr == OFS_PCLR && bus_wdata[0] && !wrap_evt) |=> !pend);
  // R6: the counter returns to zero after a wrap
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    wrap_evt |=> (value == '0));
  // R4: a stopped counter holds unless loaded
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run && !(bus_we && bus_addr == OFS_VAL)) |=> $stable(value));
  // R8: mask set and clear writes
  a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && bus_addr == OFS_MSET && bus_wdata[0]) |=> mask);
  a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && bus_addr == OFS_MCLR && bus_wdata[0]) |=> !mask);
  // R10: the output needs both bits
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> (pend && mask));
endmodule

bind rtc_topwrap rtcw_checker u_chk (
  .clk(clk), .rst_ni(rst_ni), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .run(run), .wrap_evt(wrap_evt), .value(value),
  .pend(pend), .mask(mask), .irq(irq)
);

// File: tb/tb_rtc_topwrap.sv
module tb_rtc_topwrap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_topwrap dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; ref_tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state of every readable register
    foreach (d[i]) ; // no-op
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h04, d); chk("R1 value", d, 0);
    rd(8'h08, d); chk("R1 top", d, 0);
    rd(8'h18, d); chk("R1 mask", d, 0);
    rd(8'h1C, d); chk("R1 pending", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2: field readback, strobe bit reads 0
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R2 ctrl fields", d, 32'h0000_0F05);
    wr(8'h00, 32'h0000_0302); rd(8'h00, d); chk("R2 ctrl sel only", d, 32'h0000_0300);
    wr(8'h00, 0);

    // R11: write-only and unmapped offsets read 0
    rd(8'h10, d); chk("R11 0x10", d, 0);
    rd(8'h14, d); chk("R11 0x14", d, 0);
    rd(8'h20, d); chk("R11 0x20", d, 0);
    rd(8'h0C, d); chk("R11 0x0C", d, 0);
    rd(8'h24, d); chk("R11 0x24", d, 0);

    // R3: divider sweep, value = pulses >> (sel+1)
    for (int s = 0; s < 4; s++) begin
      wr(8'h00, 0);
      wr(8'h04, 0);
      wr(8'h00, (s << 8) | 32'h3);
      for (int k = 1; k <= 20; k++) begin
        ticks(1);
        rd(8'h04, d);
        chk($sformatf("R3 sel=%0d pulses=%0d", s, k), d, k >> (s + 1));
      end
    end

    // R4: stopped counter holds; resumes from held value
    wr(8'h00, 0);
    wr(8'h04, 7);
    ticks(10);
    rd(8'h04, d); chk("R4 held while stopped", d, 7);
    wr(8'h00, 32'h3);
    ticks(2);
    rd(8'h04, d); chk("R4 resumes", d, 8);

    // R5: load then continue; load beats same-cycle advance
    wr(8'h04, 100);
    ticks(4);
    rd(8'h04, d); chk("R5 continue from load", d, 102);
    wr(8'h00, 32'h3);
    ticks(1);
    wr_tick(8'h04, 50);
    rd(8'h04, d); chk("R5 load wins", d, 50);
    ticks(2);
    rd(8'h04, d); chk("R5 after load", d, 51);

    // R6: wrap at top 3 with sel 0
    wr(8'h00, 0);
    wr(8'h08, 3);
    wr(8'h04, 0);
    wr(8'h00, 32'h7);
    for (int n = 1; n <= 4; n++) begin
      ticks(2);
      rd(8'h04, d); chk($sformatf("R6 wrap step %0d", n), d, n % 4);
    end
    rd(8'h1C, d); chk("R6/R9 pending set, masked", d, 1);
    chk("R10 irq masked", {31'b0, irq}, 0);

    // R8/R10: mask control
    wr(8'h10, 1);
    rd(8'h18, d); chk("R8 mask set", d, 1);
    chk("R10 irq on", {31'b0, irq}, 1);
    wr(8'h18, 0);
    rd(8'h18, d); chk("R8 mask read-only", d, 1);
    wr(8'h14, 1);
    rd(8'h18, d); chk("R8 mask clear", d, 0);
    chk("R10 irq off by mask", {31'b0, irq}, 0);
    wr(8'h10, 1);
    wr(8'h20, 1);
    rd(8'h1C, d); chk("R9 clear", d, 0);
    chk("R10 irq off by clear", {31'b0, irq}, 0);

    // R9: wrap in the same cycle as clear keeps pending
    wr(8'h08, 5);
    wr(8'h04, 5);
    wr(8'h00, 32'h7);
    ticks(1);
    wr_tick(8'h20, 1);
    rd(8'h1C, d); chk("R9 set beats clear", d, 1);
    rd(8'h04, d); chk("R6 zero after wrap", d, 0);
    chk("R10 irq from set", {31'b0, irq}, 1);
    wr(8'h20, 1);
    wr(8'h14, 1);

    // R7: wrap disabled passes top and rolls over silently
    wr(8'h08, 3);
    wr(8'h04, 2);
    wr(8'h00, 32'h3);
    ticks(4);
    rd(8'h04, d); chk("R7 passes top", d, 4);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'h3);
    ticks(2);
    rd(8'h04, d); chk("R7 rollover", d, 0);
    rd(8'h1C, d); chk("R7 no pending", d, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule